// File: doc/BRIEF.md
# Gamma Curve Register Packer

This block turns two sets of gamma-curve fields into the register writes a display panel expects. Each set holds fifteen small fields, one set for the positive polarity and one for the negative. On a start pulse the block captures both sets and clips every field to its legal width. It then emits bytes on a stream with a command/data flag and a valid/ready handshake.

The first write always selects the gamma curve. The select value is the low two bits of negative field 14. It is sent as command 0x26 with the one-hot argument `1 << select`. Only curve 0 can be customised. For any other curve the block ends right after that write. For curve 0 it goes on to send the packed coefficient register for each polarity. After the last byte it holds off for a programmable settle time and then pulses `done`.

The block sits between a controller that owns the gamma settings and a serial shifter that drives the panel. The stream is meant to feed that shifter directly.

Top module: `gpk_gamma_packer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `valid_o`, `busy_o` and `done_o` are all low.
- R2: A `start_i` sampled while the block is idle captures both field buses. Field i sits at bits [5i+4:5i]. A `start_i` sampled while `busy_o` is high is ignored, and the byte stream of the sequence in progress does not change.
- R3: Every field is clipped when captured. The masks for fields 0 to 14 are 0x0F, 0x0F, 0x1F, 0x0F, 0x0F, 0x0F, 0x1F, then 0x07 for fields 7 to 12, then 0x03 and 0x03. The negative set uses the same masks, except that field 13 is forced to 0 and field 14 keeps 2 bits.
- R4: The first byte is a command (`is_cmd_o`=1) of value 0x26. The second byte is data (`is_cmd_o`=0) of value `1 << sel`, where sel is bits [1:0] of negative field 14.
- R5: When sel is nonzero, the sequence ends after those two bytes. No wait follows, and `done_o` rises in the cycle after the second byte is accepted.
- R6: When sel is 0, command 0xC2 follows, then nine data bytes built from the positive set. With {a,b} meaning (a<<4)|b, the bytes are {f8,f7}, {f10,f9}, {f12,f11}, f2, {f4,f3}, f5, f6, {f1,f0}, and (f14<<2)|f13.
- R7: After that, command 0xC3 follows with eight data bytes. These are the first eight bytes of the R6 layout, built from the negative set.
- R8: After the last 0xC3 data byte is accepted, `busy_o` stays high with `valid_o` low for exactly WAIT_CYCLES cycles. `done_o` follows.
- R9: `done_o` is high for exactly one cycle, the first idle cycle after a sequence. A `start_i` sampled in that cycle starts a new sequence.
- R10: While `valid_o` is high and `ready_i` is low, `valid_o`, `byte_o` and `is_cmd_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a sequence (accepted only when idle) |
| pos_fields_i | input | 75 | Positive-polarity fields, field i at [5i+4:5i] |
| neg_fields_i | input | 75 | Negative-polarity fields, field i at [5i+4:5i] |
| ready_i | input | 1 | Downstream accepts the current byte |
| valid_o | output | 1 | A byte is offered |
| is_cmd_o | output | 1 | 1 = command byte, 0 = data byte |
| byte_o | output | 8 | Offered byte |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two functions can fall in the same cycle: the end of one sequence, signalled by the `done_o` pulse, and the acceptance of the next `start_i`. The bench raises `start_i` at the falling edge where it first sees `done_o` high. It then expects the next falling edge to show a fresh 0x26 command with `valid_o` high. The second sequence must then run to a normal completion. Separately, a start pulse raised in the middle of a stalled sequence, with different fields, must leave the captured byte stream identical to the expected one.

// File: rtl/gpk_pkg.sv
`timescale 1ns/1ps
package gpk_pkg;

    localparam int unsigned NUM_FIELDS = 15;
    localparam int unsigned FIELD_W    = 5;
    localparam int unsigned BUS_W      = NUM_FIELDS * FIELD_W;
    localparam int unsigned IDX_W      = 5;
    localparam int unsigned SEL_LSB    = 14 * FIELD_W;

    localparam logic [7:0] OP_SELECT = 8'h26;
    localparam logic [7:0] OP_POS    = 8'hC2;
    localparam logic [7:0] OP_NEG    = 8'hC3;

    localparam int unsigned POS_BYTES = 9;
    localparam int unsigned NEG_BYTES = 8;

    localparam logic [IDX_W-1:0] IDX_OP_SEL  = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_SEL_ARG = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_POS_OP  = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_NEG_OP  = IDX_W'(2 + 1 + POS_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST    = IDX_W'(2 + 1 + POS_BYTES + 1 + NEG_BYTES - 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    function automatic logic [FIELD_W-1:0] field_mask(input logic neg, input int unsigned idx);
        logic [FIELD_W-1:0] m;
        case (idx)
            0, 1, 3, 4, 5:          m = 5'h0F;
            2, 6:                   m = 5'h1F;
            7, 8, 9, 10, 11, 12:    m = 5'h07;
            13:                     m = neg ? 5'h00 : 5'h03;
            14:                     m = 5'h03;
            default:                m = 5'h00;
        endcase
        return m;
    endfunction

    function automatic logic [FIELD_W-1:0] fld(input logic [BUS_W-1:0] f, input int unsigned i);
        return f[i*FIELD_W +: FIELD_W];
    endfunction

    function automatic logic [7:0] nib_pair(input logic [FIELD_W-1:0] hi, input logic [FIELD_W-1:0] lo);
        return {hi[3:0], lo[3:0]};
    endfunction

    // k-th byte of a coefficient register built from one field set
    function automatic logic [7:0] coef_byte(input logic [BUS_W-1:0] f, input int unsigned k);
        logic [7:0] b;
        case (k)
            0:       b = nib_pair(fld(f, 8),  fld(f, 7));
            1:       b = nib_pair(fld(f, 10), fld(f, 9));
            2:       b = nib_pair(fld(f, 12), fld(f, 11));
            3:       b = {3'b000, fld(f, 2)};
            4:       b = nib_pair(fld(f, 4),  fld(f, 3));
            5:       b = {3'b000, fld(f, 5)};
            6:       b = {3'b000, fld(f, 6)};
            7:       b = nib_pair(fld(f, 1),  fld(f, 0));
            8:       b = {4'b0000, fld(f, 14)[1:0], fld(f, 13)[1:0]};
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/gpk_field_mask.sv
`timescale 1ns/1ps
module gpk_field_mask
    import gpk_pkg::*;
#(
    parameter bit IS_NEG = 1'b0
) (
    input  logic [BUS_W-1:0] raw_i,
    output logic [BUS_W-1:0] masked_o
);

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        assign masked_o[g*FIELD_W +: FIELD_W] =
            raw_i[g*FIELD_W +: FIELD_W] & field_mask(IS_NEG, g);
    end

endmodule

// File: rtl/gpk_byte_gen.sv
`timescale 1ns/1ps
module gpk_byte_gen
    import gpk_pkg::*;
(
    input  logic [BUS_W-1:0] pos_i,
    input  logic [BUS_W-1:0] neg_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       byte_o,
    output logic             is_cmd_o
);

    logic [1:0]  sel;
    int unsigned pos_k;
    int unsigned neg_k;

    assign sel   = neg_i[SEL_LSB +: 2];
    assign pos_k = 32'(idx_i) - 32'(IDX_POS_OP) - 32'd1;
    assign neg_k = 32'(idx_i) - 32'(IDX_NEG_OP) - 32'd1;

    always_comb begin
        byte_o   = 8'h00;
        is_cmd_o = 1'b0;
        if (idx_i == IDX_OP_SEL) begin
            byte_o   = OP_SELECT;
            is_cmd_o = 1'b1;
        end else if (idx_i == IDX_SEL_ARG) begin
            byte_o   = 8'd1 << sel;
        end else if (idx_i == IDX_POS_OP) begin
            byte_o   = OP_POS;
            is_cmd_o = 1'b1;
        end else if (idx_i == IDX_NEG_OP) begin
            byte_o   = OP_NEG;
            is_cmd_o = 1'b1;
        end else if (idx_i < IDX_NEG_OP) begin
            byte_o   = coef_byte(pos_i, pos_k);
        end else begin
            byte_o   = coef_byte(neg_i, neg_k);
        end
    end

endmodule

// File: rtl/gpk_wait_timer.sv
`timescale 1ns/1ps
module gpk_wait_timer #(
    parameter int unsigned WAIT_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expire_o
);

    localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CNT_W'(WAIT_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/gpk_gamma_packer.sv
`timescale 1ns/1ps
module gpk_gamma_packer
    import gpk_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 1250000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [BUS_W-1:0] pos_fields_i,
    input  logic [BUS_W-1:0] neg_fields_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic             is_cmd_o,
    output logic [7:0]       byte_o,
    output logic             busy_o,
    output logic             done_o
);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [BUS_W-1:0] pos;
        logic [BUS_W-1:0] neg;
        logic             done;
    } seq_t;

    seq_t d, q;

    logic [BUS_W-1:0] pos_masked;
    logic [BUS_W-1:0] neg_masked;
    logic             wait_load;
    logic             wait_expire;
    logic             accept;

    gpk_field_mask #(.IS_NEG(1'b0)) i_mask_pos (
        .raw_i    (pos_fields_i),
        .masked_o (pos_masked)
    );

    gpk_field_mask #(.IS_NEG(1'b1)) i_mask_neg (
        .raw_i    (neg_fields_i),
        .masked_o (neg_masked)
    );

    gpk_byte_gen i_byte_gen (
        .pos_i    (q.pos),
        .neg_i    (q.neg),
        .idx_i    (q.idx),
        .byte_o   (byte_o),
        .is_cmd_o (is_cmd_o)
    );

    gpk_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) i_wait (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (wait_load),
        .expire_o (wait_expire)
    );

    assign accept    = (q.state == ST_SEND) && ready_i;
    assign wait_load = accept && (q.idx == IDX_LAST);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state = ST_SEND;
                    d.idx   = IDX_OP_SEL;
                    d.pos   = pos_masked;
                    d.neg   = neg_masked;
                end
            end
            ST_SEND: begin
                if (accept) begin
                    if ((q.idx == IDX_SEL_ARG) && (q.neg[SEL_LSB +: 2] != 2'd0)) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end else if (q.idx == IDX_LAST) begin
                        d.state = ST_WAIT;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (wait_expire) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{state: ST_IDLE, idx: '0, pos: '0, neg: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign valid_o = (q.state == ST_SEND);
    assign busy_o  = (q.state != ST_IDLE);
    assign done_o  = q.done;

endmodule

// File: rtl/gpk_checker.sv
`timescale 1ns/1ps
module gpk_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       ready_i,
    input logic       valid_o,
    input logic       is_cmd_o,
    input logic [7:0] byte_o,
    input logic       busy_o,
    input logic       done_o
);

    AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !ready_i) |=> (valid_o && $stable(byte_o) && $stable(is_cmd_o))); // R10

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R9

    AST_FIRST_IS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (valid_o && is_cmd_o && byte_o == 8'h26)); // R4

    AST_CMD_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && is_cmd_o) |-> (byte_o == 8'h26 || byte_o == 8'hC2 || byte_o == 8'hC3)); // R6

    AST_SELECT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && ready_i && is_cmd_o && byte_o == 8'h26) |=> (valid_o && !is_cmd_o && $onehot0(byte_o) && byte_o != 8'h00)); // R4

    AST_VALID_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> busy_o); // R1

endmodule

bind gpk_gamma_packer gpk_checker i_gpk_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ready_i  (ready_i),
    .valid_o  (valid_o),
    .is_cmd_o (is_cmd_o),
    .byte_o   (byte_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/test_gpk_gamma_packer.sv
`timescale 1ns/1ps
module test_gpk_gamma_packer;

    localparam int unsigned WAIT_CYCLES = 12;
    localparam int unsigned NV = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [74:0] pos = '0;
    logic [74:0] neg = '0;
    logic        ready = 1'b1;
    logic        valid, is_cmd, busy, done;
    logic [7:0]  byte_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gpk_gamma_packer #(.WAIT_CYCLES(WAIT_CYCLES)) i_gpk_gamma_packer (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .pos_fields_i (pos),
        .neg_fields_i (neg),
        .ready_i      (ready),
        .valid_o      (valid),
        .is_cmd_o     (is_cmd),
        .byte_o       (byte_out),
        .busy_o       (busy),
        .done_o       (done)
    );

    // stimulus vectors: positive set, negative set, stall pattern
    localparam logic [74:0] VP [NV] = '{
        {15{5'h1F}},
        {15{5'h1F}},
        {5'd14, 5'd13, 5'd12, 5'd11, 5'd10, 5'd9, 5'd8, 5'd7, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0},
        {15{5'h15}},
        {15{5'h0A}},
        75'd0
    };
    localparam logic [74:0] VN [NV] = '{
        {5'h00, {14{5'h1F}}},
        {15{5'h1F}},
        {5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd14},
        {5'h01, {14{5'h0C}}},
        {5'h1E, {14{5'h13}}},
        75'd0
    };
    localparam bit VS [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

    logic [7:0] cap_b [32];
    logic       cap_c [32];
    int         cap_n, wait_cnt;
    bit         got_done;
    logic [7:0] exp_b [32];
    logic       exp_c [32];
    int         exp_n;

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [4:0] mask_of(input bit neg_set, input int i);
        if (i == 2 || i == 6) return 5'h1F;
        if (i >= 7 && i <= 12) return 5'h07;
        if (i == 13) return neg_set ? 5'h00 : 5'h03;
        if (i == 14) return 5'h03;
        return 5'h0F;
    endfunction

    function automatic logic [7:0] f(input logic [74:0] v, input bit neg_set, input int i);
        return 8'(v[i*5 +: 5] & mask_of(neg_set, i));
    endfunction

    function automatic logic [7:0] reg_byte(input logic [74:0] v, input bit ns, input int k);
        case (k)
            0: return (f(v, ns, 8) << 4) | f(v, ns, 7);
            1: return (f(v, ns, 10) << 4) | f(v, ns, 9);
            2: return (f(v, ns, 12) << 4) | f(v, ns, 11);
            3: return f(v, ns, 2);
            4: return (f(v, ns, 4) << 4) | f(v, ns, 3);
            5: return f(v, ns, 5);
            6: return f(v, ns, 6);
            7: return (f(v, ns, 1) << 4) | f(v, ns, 0);
            default: return (f(v, ns, 14) << 2) | f(v, ns, 13);
        endcase
    endfunction

    task automatic build_expect(input logic [74:0] p, input logic [74:0] n);
        int sel;
        sel = int'(n[71:70]);
        exp_n = 0;
        exp_b[exp_n] = 8'h26; exp_c[exp_n] = 1; exp_n++;
        exp_b[exp_n] = 8'(1 << sel); exp_c[exp_n] = 0; exp_n++;
        if (sel == 0) begin
            exp_b[exp_n] = 8'hC2; exp_c[exp_n] = 1; exp_n++;
            for (int k = 0; k < 9; k++) begin
                exp_b[exp_n] = reg_byte(p, 0, k); exp_c[exp_n] = 0; exp_n++;
            end
            exp_b[exp_n] = 8'hC3; exp_c[exp_n] = 1; exp_n++;
            for (int k = 0; k < 8; k++) begin
                exp_b[exp_n] = reg_byte(n, 1, k); exp_c[exp_n] = 0; exp_n++;
            end
        end
    endtask

    // run one sequence; poke: pulse start with other fields mid-way; chain: restart in done cycle
    task automatic run_seq(input logic [74:0] p, input logic [74:0] n, input bit stall,
                           input bit poke, input bit chain);
        @(negedge clk);
        pos = p; neg = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cap_n = 0; wait_cnt = 0; got_done = 0;
        for (int c = 0; c < 4000 && !got_done; c++) begin
            ready = stall ? (c % 3 != 1) : 1'b1;
            if (poke && c == 5) begin start = 1'b1; pos = ~p; neg = 75'd0; end
            if (poke && c == 6) start = 1'b0;
            #1;
            if (valid && ready && cap_n < 32) begin
                cap_b[cap_n] = byte_out; cap_c[cap_n] = is_cmd; cap_n++;
            end else if (busy && !valid) begin
                wait_cnt++;
            end
            if (done) begin
                got_done = 1;
                if (chain) start = 1'b1;
            end
            if (!got_done) @(negedge clk);
        end
        ready = 1'b1;
    endtask

    task automatic compare(input string tag);
        check(got_done, "R9", {tag, " done seen"}, int'(got_done), 1);
        check(cap_n == exp_n, "R5", {tag, " byte count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            check(cap_b[i] == exp_b[i] && cap_c[i] == exp_c[i],
                  (i < 2) ? "R4" : (i < 12) ? "R6" : "R7",
                  $sformatf("%s byte %0d", tag, i), {cap_c[i], cap_b[i]}, {exp_c[i], exp_b[i]});
        end
        check(wait_cnt == ((exp_n > 2) ? WAIT_CYCLES : 0), "R8", {tag, " settle cycles"},
              wait_cnt, (exp_n > 2) ? WAIT_CYCLES : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired: actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!valid && !busy && !done, "R1", "idle in reset", {valid, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!valid && !busy && !done, "R1", "idle after reset", {valid, busy, done}, 0);

        // table walk: R3 masks, R4..R8 stream, R10 stalls
        for (int v = 0; v < NV; v++) begin
            build_expect(VP[v], VN[v]);
            run_seq(VP[v], VN[v], VS[v], 0, 0);
            compare($sformatf("vec%0d", v));
            @(negedge clk);
            check(!done, "R9", "done lasts one cycle", int'(done), 0);
        end

        // R2: start while busy is ignored
        build_expect(VP[2], VN[2]);
        run_seq(VP[2], VN[2], 1, 1, 0);
        compare("r2_busy_start");

        // R9: done cycle and new start coincide
        build_expect(VP[0], VN[0]);
        run_seq(VP[0], VN[0], 0, 0, 1);
        @(negedge clk);
        start = 1'b0;
        #1;
        check(valid && is_cmd && byte_out == 8'h26, "R9", "restart in done cycle",
              {valid, is_cmd, byte_out}, {1'b1, 1'b1, 8'h26});
        for (int c = 0; c < 200 && !done; c++) @(negedge clk);
        #1;
        check(done && !busy, "R9", "chained sequence completes", {done, busy}, 2'b10);

        // R1: reset in mid-sequence returns to idle
        @(negedge clk);
        pos = VP[2]; neg = VN[2]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!valid && !busy && !done, "R1", "mid-sequence reset", {valid, busy, done}, 0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule